// File: doc/BRIEF.md
# Trim Calibration Sequencer

This block is the digital controller of a clock/data receiver front end that trims its own analog imperfections. A software write of the start control bit launches a fixed run of four calibrations, in this order: charge-pump and output-buffer offset, clock pulse width, data rising-edge delay and data falling-edge delay. For each calibration the block presents a step code to the analog side, so that the analog side injects the matching stimulus. It then searches a 6-bit trim code by successive approximation. The search reads a single comparator bit that reports whether the monitored analog output lies above its reference level.

The block keeps two copies of each trim code. One is the working copy used during a run. The other is the kept result that the analog side sees between runs. When a run completes, the start bit clears itself and an open-drain completion monitor pulls low. A bypass bit tells the front end to ignore the trim results and pass the raw clock and data through. Sleep powers the analog side down and keeps the last results. Two test-select bits route internal pump or phase-comparator signals onto the two monitor outputs.

Top module: `trimcal_seq`

## Requirements
- R1: A one-cycle `start_wr` pulse while idle and not asleep launches a run on that clock edge. `start_bit` reads 1 for the whole run and clears itself when the run finishes. A run lasts 4*TRIM_W*SETTLE+1 cycles (385 with the defaults).
- R2: `step_sel` shows 0 when idle. During a run it shows 1 (offset), then 2 (pulse width), then 3 (rising delay), then 4 (falling delay), and it only ever advances by one.
- R3: After power-on reset, and at every launch, all four trim codes equal the midpoint 2^(TRIM_W-1) (32, binary 100000). `trim_code[s*TRIM_W +: TRIM_W]` carries step s, where s=0 is offset and s=3 is falling delay.
- R4: Each step decides its bits MSB first. A bit decision is taken SETTLE clocks after the trial code appears. `cmp_above`=1 clears the trial bit. The kept code of each step is the largest code that the comparator does not report as above.
- R5: With test select 00, `mon0_oe` is 0 for the whole run. After a run completes it is 1 with `mon0_val`=0 (pulled low). A launch clears it again.
- R6: While idle, `bypass`=1 drives `trim_apply` to 0. A run started with bypass set still runs to completion, applies its trial codes during the run, and keeps its results.
- R7: Power-on reset leaves `start_bit`=0, `step_sel`=0, `mon0_oe`=0, `mon1_test`=0, `trim_apply`=1 and `analog_en`=1.
- R8: `sleep`=1 drives `analog_en` to 0. Sleep during a run aborts it on the next edge. The previously kept codes are restored and the completion monitor stays released. Kept codes are unchanged after waking.
- R9: Test select 01 drives `mon0` with `chg_sig` and `mon1` with `dis_sig`. Test select 10 drives them with `pc_clk` and `pc_dat`. In both modes `mon0_oe`=1 and `mon1_test`=1. Selects 00 and 11 give normal behaviour, with `mon1_test`=0 and `mon1_val`=0.
- R10: A `start_wr` pulse during a run, or while asleep, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_wr | input | 1 | One-cycle write of 1 to the start bit |
| bypass | input | 1 | Result-bypass control bit |
| sleep | input | 1 | Sleep control bit |
| test_sel | input | 2 | Monitor test select |
| cmp_above | input | 1 | Comparator: monitored output above reference |
| chg_sig | input | 1 | Internal charge signal |
| dis_sig | input | 1 | Internal discharge signal |
| pc_clk | input | 1 | Phase-comparator clock input |
| pc_dat | input | 1 | Phase-comparator data input |
| start_bit | output | 1 | Start bit readback, 1 while running |
| step_sel | output | 3 | Stimulus selection for the analog side |
| trim_code | output | 4*TRIM_W | Four trim codes, step 0 in the low bits |
| trim_apply | output | 1 | Front end uses trim codes (0 means raw path) |
| analog_en | output | 1 | Analog power enable |
| mon0_oe | output | 1 | Monitor 0 drive enable (0 means high impedance) |
| mon0_val | output | 1 | Monitor 0 driven value |
| mon1_test | output | 1 | Monitor 1 carries a test signal |
| mon1_val | output | 1 | Monitor 1 test value |

## Verification
The assertions assume that `start_wr` is a single-cycle pulse and that the comparator bit depends only on the trim code on the port. They also assume that test select does not change during a run while the completion monitor is being judged. The bench models the comparator as a combinational comparison of the active step's code with a per-step target. It changes control bits only on falling edges and holds test select at 00 for every run. Random targets, bypass settings and test-mode patterns come from a fixed seed. Directed cases add the end codes 0 and 63, a second start in the middle of a run, a start while asleep and an abort by sleep.

// File: rtl/trimcal_pkg.sv
package trimcal_pkg;
   localparam int unsigned N_STEP = 4;

   typedef enum logic [2:0] {
      STEP_IDLE   = 3'd0,
      STEP_OFFSET = 3'd1,
      STEP_PWIDTH = 3'd2,
      STEP_RISE   = 3'd3,
      STEP_FALL   = 3'd4
   } step_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_WRAP = 2'd2
   } seq_e;

   typedef enum logic [1:0] {
      TM_NORMAL = 2'b00,
      TM_PUMP   = 2'b01,
      TM_PHASE  = 2'b10,
      TM_SPARE  = 2'b11
   } tmode_e;
endpackage

// File: rtl/trimcal_ctrl.sv
module trimcal_ctrl
   import trimcal_pkg::*;
#(
   parameter int unsigned TRIM_W = 6,
   parameter int unsigned SETTLE = 16,
   localparam int unsigned BIT_W = $clog2(TRIM_W),
   localparam int unsigned CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_wr,
   input  logic             sleep,
   output logic             busy,
   output logic             launch,
   output logic             finish,
   output logic             abort,
   output logic             decide,
   output logic [1:0]       step_idx,
   output logic [BIT_W-1:0] bit_idx,
   output logic [2:0]       step_sel
);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(SETTLE - 1);
   localparam logic [BIT_W-1:0] BIT_TOP   = BIT_W'(TRIM_W - 1);
   localparam logic [1:0]       STEP_LAST = 2'(N_STEP - 1);

   seq_e             state;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       step_num;

   assign busy   = (state != SEQ_IDLE);
   assign launch = (state == SEQ_IDLE) && start_wr && !sleep;
   assign abort  = busy && sleep;
   assign decide = (state == SEQ_RUN) && !sleep && (cnt == CNT_LAST);
   assign finish = (state == SEQ_WRAP) && !sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         cnt      <= '0;
         step_idx <= '0;
         bit_idx  <= BIT_TOP;
      end else if (abort) begin
         state <= SEQ_IDLE;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (launch) begin
                  state    <= SEQ_RUN;
                  cnt      <= '0;
                  step_idx <= '0;
                  bit_idx  <= BIT_TOP;
               end
            end
            SEQ_RUN: begin
               if (decide) begin
                  cnt <= '0;
                  if (bit_idx == '0) begin
                     bit_idx <= BIT_TOP;
                     if (step_idx == STEP_LAST) state <= SEQ_WRAP;
                     else step_idx <= step_idx + 2'd1;
                  end else begin
                     bit_idx <= bit_idx - 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_WRAP: state <= SEQ_IDLE;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign step_num = {1'b0, step_idx} + 3'd1;
   assign step_sel = busy ? step_num : 3'(STEP_IDLE);
endmodule

// File: rtl/trimcal_sar_reg.sv
module trimcal_sar_reg #(
   parameter int unsigned TRIM_W = 6,
   localparam int unsigned BIT_W = $clog2(TRIM_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              finish,
   input  logic              sel,
   input  logic              busy,
   input  logic [BIT_W-1:0]  bit_idx,
   input  logic              cmp_above,
   output logic [TRIM_W-1:0] code
);
   localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

   logic [TRIM_W-1:0] work;
   logic [TRIM_W-1:0] keep;
   logic [TRIM_W-1:0] nxt;

   always_comb begin
      nxt = work;
      if (cmp_above) nxt[bit_idx] = 1'b0;
      if (bit_idx != '0) nxt[bit_idx - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work <= MID;
         keep <= MID;
      end else begin
         if (launch)   work <= MID;
         else if (sel) work <= nxt;
         if (finish)   keep <= work;
      end
   end

   assign code = busy ? work : keep;
endmodule

// File: rtl/trimcal_monmux.sv
module trimcal_monmux
   import trimcal_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] test_sel,
   input  logic       done,
   input  logic       chg_sig,
   input  logic       dis_sig,
   input  logic       pc_clk,
   input  logic       pc_dat,
   output logic       mon0_oe,
   output logic       mon0_val,
   output logic       mon1_test,
   output logic       mon1_val
);
   logic [3:0] pick;

   always_comb begin
      unique case (tmode_e'(test_sel))
         TM_PUMP:  pick = {1'b1, chg_sig, 1'b1, dis_sig};
         TM_PHASE: pick = {1'b1, pc_clk, 1'b1, pc_dat};
         default:  pick = {done, 1'b0, 1'b0, 1'b0};
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [3:0] pick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pick_q <= '0;
            else        pick_q <= pick;
         end
         assign {mon0_oe, mon0_val, mon1_test, mon1_val} = pick_q;
      end else begin : g_comb
         assign {mon0_oe, mon0_val, mon1_test, mon1_val} = pick;
      end
   endgenerate
endmodule

// File: rtl/trimcal_seq.sv
module trimcal_seq
   import trimcal_pkg::*;
#(
   parameter int unsigned TRIM_W  = 6,
   parameter int unsigned SETTLE  = 16,
   parameter bit          MON_REG = 1'b0,
   localparam int unsigned BIT_W  = $clog2(TRIM_W),
   localparam int unsigned CODE_W = N_STEP * TRIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic              bypass,
   input  logic              sleep,
   input  logic [1:0]        test_sel,
   input  logic              cmp_above,
   input  logic              chg_sig,
   input  logic              dis_sig,
   input  logic              pc_clk,
   input  logic              pc_dat,
   output logic              start_bit,
   output logic [2:0]        step_sel,
   output logic [CODE_W-1:0] trim_code,
   output logic              trim_apply,
   output logic              analog_en,
   output logic              mon0_oe,
   output logic              mon0_val,
   output logic              mon1_test,
   output logic              mon1_val
);
   generate
      if (TRIM_W < 2 || TRIM_W > 16) begin : g_bad_width
         $error("trimcal_seq: TRIM_W must lie in 2..16");
      end
      if (SETTLE < 1 || SETTLE > 65536) begin : g_bad_settle
         $error("trimcal_seq: SETTLE must lie in 1..65536");
      end
   endgenerate

   logic             busy, launch, finish, abort, decide;
   logic [1:0]       step_idx;
   logic [BIT_W-1:0] bit_idx;
   logic             done;

   trimcal_ctrl #(.TRIM_W(TRIM_W), .SETTLE(SETTLE)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_wr (start_wr),
      .sleep    (sleep),
      .busy     (busy),
      .launch   (launch),
      .finish   (finish),
      .abort    (abort),
      .decide   (decide),
      .step_idx (step_idx),
      .bit_idx  (bit_idx),
      .step_sel (step_sel)
   );

   generate
      for (genvar s = 0; s < N_STEP; s++) begin : g_step
         trimcal_sar_reg #(.TRIM_W(TRIM_W)) u_sar (
            .clk       (clk),
            .rst_n     (rst_n),
            .launch    (launch),
            .finish    (finish),
            .sel       (decide && (step_idx == 2'(s))),
            .busy      (busy),
            .bit_idx   (bit_idx),
            .cmp_above (cmp_above),
            .code      (trim_code[s*TRIM_W +: TRIM_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done <= 1'b0;
      else if (launch) done <= 1'b0;
      else if (finish) done <= 1'b1;
   end

   trimcal_monmux #(.REG_OUT(MON_REG)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_sel  (test_sel),
      .done      (done),
      .chg_sig   (chg_sig),
      .dis_sig   (dis_sig),
      .pc_clk    (pc_clk),
      .pc_dat    (pc_dat),
      .mon0_oe   (mon0_oe),
      .mon0_val  (mon0_val),
      .mon1_test (mon1_test),
      .mon1_val  (mon1_val)
   );

   assign start_bit  = busy;
   assign trim_apply = busy || !bypass;
   assign analog_en  = !sleep;
endmodule

// File: rtl/trimcal_seq_chk.sv
module trimcal_seq_chk #(
   parameter int unsigned TRIM_W  = 6,
   parameter bit          MON_REG = 1'b0,
   localparam int unsigned CODE_W = 4 * TRIM_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_wr,
   input logic              sleep,
   input logic [1:0]        test_sel,
   input logic              start_bit,
   input logic [2:0]        step_sel,
   input logic [CODE_W-1:0] trim_code,
   input logic              mon0_oe
);
   localparam logic [TRIM_W-1:0] MID     = TRIM_W'(1) << (TRIM_W - 1);
   localparam logic [CODE_W-1:0] ALL_MID = {4{MID}};

   // R2: the step code holds or advances by one while a run continues
   a_r2_step_order: assert property (@(posedge clk) disable iff (!rst_n)
      (start_bit && $past(start_bit) && step_sel != 3'd0)
         |-> (step_sel == $past(step_sel) || step_sel == $past(step_sel) + 3'd1));

   // R3: every code sits at midpoint on the first cycle of a run
   a_r3_mid_at_launch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_bit) |-> trim_code == ALL_MID);

   // R8: sleep forces the sequencer idle on the next edge
   a_r8_sleep_idles: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> step_sel == 3'd0);

   // R8: codes seen by the analog side stay put between runs
   a_r8_codes_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_bit && !$past(start_bit)) |-> $stable(trim_code));

   // R10: a start write while asleep does not launch
   a_r10_no_start_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !start_bit) |=> !start_bit);

   // R1: a start write while idle and awake launches
   a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !sleep && !start_bit) |=> start_bit);

   generate
      if (!MON_REG) begin : g_mon
         // R5: completion monitor released during a run in normal mode
         a_r5_hiz_running: assert property (@(posedge clk) disable iff (!rst_n)
            (start_bit && test_sel == 2'b00) |-> !mon0_oe);
         // R5: completion monitor pulls after a finished run
         a_r5_done_pull: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(start_bit) && !$past(sleep) && test_sel == 2'b00) |-> mon0_oe);
      end
   endgenerate
endmodule

bind trimcal_seq trimcal_seq_chk #(.TRIM_W(TRIM_W), .MON_REG(MON_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_wr  (start_wr),
   .sleep     (sleep),
   .test_sel  (test_sel),
   .start_bit (start_bit),
   .step_sel  (step_sel),
   .trim_code (trim_code),
   .mon0_oe   (mon0_oe)
);

// File: tb/trimcal_seq_test.sv
`timescale 1ns/1ps
module trimcal_seq_test;
   localparam int W = 6;
   localparam int SET = 16;
   localparam int RUN_LEN = 4 * W * SET + 1;
   localparam logic [W-1:0] MID = 6'd32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_wr = 1'b0, bypass = 1'b0, sleep = 1'b0;
   logic [1:0] test_sel = 2'b00;
   logic cmp_above;
   logic chg_sig = 1'b0, dis_sig = 1'b0, pc_clk = 1'b0, pc_dat = 1'b0;
   logic start_bit, trim_apply, analog_en, mon0_oe, mon0_val, mon1_test, mon1_val;
   logic [2:0] step_sel;
   logic [4*W-1:0] trim_code;
   logic [W-1:0] tgt [4];
   int checks = 0, errors = 0, cyc = 0;

   always #2 clk = ~clk;

   trimcal_seq uut (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .bypass(bypass), .sleep(sleep),
      .test_sel(test_sel), .cmp_above(cmp_above), .chg_sig(chg_sig), .dis_sig(dis_sig),
      .pc_clk(pc_clk), .pc_dat(pc_dat), .start_bit(start_bit), .step_sel(step_sel),
      .trim_code(trim_code), .trim_apply(trim_apply), .analog_en(analog_en),
      .mon0_oe(mon0_oe), .mon0_val(mon0_val), .mon1_test(mon1_test), .mon1_val(mon1_val)
   );

   // analog model: output above reference when the active code exceeds its target
   always_comb begin
      cmp_above = 1'b0;
      if (step_sel >= 3'd1 && step_sel <= 3'd4)
         cmp_above = trim_code[(int'(step_sel) - 1) * W +: W] > tgt[int'(step_sel) - 1];
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] sar_expect(input logic [W-1:0] t);
      logic [W-1:0] c = '0;
      for (int b = W - 1; b >= 0; b--) begin
         logic [W-1:0] trial = c | (W'(1) << b);
         if (!(trial > t)) c = trial;
      end
      return c;
   endfunction

   function automatic logic [4*W-1:0] pack_expect();
      logic [4*W-1:0] p;
      for (int s = 0; s < 4; s++) p[s*W +: W] = sar_expect(tgt[s]);
      return p;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run_cal(input bit poke_mid, output int dur, output bit order_ok, output bit hiz_ok, output bit apply_ok);
      logic [2:0] prev = 3'd0;
      @(negedge clk) start_wr = 1'b1;
      @(negedge clk) start_wr = 1'b0;
      chk("R3", "codes at launch", trim_code, {4{MID}});
      dur = 0; order_ok = 1'b1; hiz_ok = 1'b1; apply_ok = 1'b1;
      while (start_bit && dur < 2000) begin
         dur++;
         if (step_sel != prev) begin
            if (step_sel != prev + 3'd1) order_ok = 1'b0;
            prev = step_sel;
         end
         if (test_sel == 2'b00 && mon0_oe) hiz_ok = 1'b0;
         if (!trim_apply) apply_ok = 1'b0;
         start_wr = poke_mid && (dur == 150);
         @(negedge clk);
      end
      start_wr = 1'b0;
      if (prev != 3'd4) order_ok = 1'b0;
   endtask

   initial begin
      int dur;
      bit ord, hiz, app;
      logic [4*W-1:0] kept;
      void'($urandom(32'h1d5e_0c4a));
      for (int s = 0; s < 4; s++) tgt[s] = '0;

      // R7 / R3: power-on state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7", "start_bit after reset", start_bit, 0);
      chk("R7", "step_sel after reset", step_sel, 0);
      chk("R7", "mon0_oe after reset", mon0_oe, 0);
      chk("R7", "mon1_test after reset", mon1_test, 0);
      chk("R7", "trim_apply after reset", trim_apply, 1);
      chk("R7", "analog_en after reset", analog_en, 1);
      chk("R3", "codes after reset", trim_code, {4{MID}});

      // directed end codes
      tgt[0] = 6'd0; tgt[1] = 6'd63; tgt[2] = 6'd32; tgt[3] = 6'd31;
      run_cal(1'b0, dur, ord, hiz, app);
      chk("R1", "run length", dur, RUN_LEN);
      chk("R1", "start bit cleared", start_bit, 0);
      chk("R2", "step order", ord, 1);
      chk("R5", "monitor released during run", hiz, 1);
      chk("R4", "codes for 0/63/32/31", trim_code, pack_expect());
      chk("R5", "monitor pulls after run", {mon0_oe, mon0_val}, 2'b10);
      chk("R2", "step idle after run", step_sel, 0);

      // random targets, random bypass
      for (int r = 0; r < 4; r++) begin
         for (int s = 0; s < 4; s++) tgt[s] = W'($urandom);
         bypass = 1'($urandom);
         run_cal(1'b0, dur, ord, hiz, app);
         chk("R4", "codes for random targets", trim_code, pack_expect());
         chk("R1", "random run length", dur, RUN_LEN);
         chk("R6", "trial codes applied during run", app, 1);
         chk("R6", "trim_apply after run", trim_apply, !bypass);
         chk("R5", "monitor after random run", mon0_oe, 1);
      end
      bypass = 1'b0;

      // R10: start in the middle of a run is ignored
      for (int s = 0; s < 4; s++) tgt[s] = W'($urandom);
      run_cal(1'b1, dur, ord, hiz, app);
      chk("R10", "run length with second start", dur, RUN_LEN);
      chk("R10", "codes with second start", trim_code, pack_expect());

      // R6: start and bypass together
      bypass = 1'b1;
      for (int s = 0; s < 4; s++) tgt[s] = W'($urandom);
      run_cal(1'b0, dur, ord, hiz, app);
      chk("R6", "bypass run completes", dur, RUN_LEN);
      chk("R6", "bypass run keeps codes", trim_code, pack_expect());
      chk("R6", "bypass disables result", trim_apply, 0);
      bypass = 1'b0;
      @(negedge clk);
      chk("R6", "result applied once bypass drops", trim_apply, 1);

      // R8: sleep aborts a run and keeps the previous codes
      kept = trim_code;
      for (int s = 0; s < 4; s++) tgt[s] = ~tgt[s];
      @(negedge clk) start_wr = 1'b1;
      @(negedge clk) start_wr = 1'b0;
      repeat (100) @(negedge clk);
      chk("R5", "monitor cleared by launch", mon0_oe, 0);
      sleep = 1'b1;
      @(negedge clk);
      chk("R8", "abort clears start bit", start_bit, 0);
      chk("R8", "abort idles steps", step_sel, 0);
      chk("R8", "abort keeps monitor released", mon0_oe, 0);
      chk("R8", "abort restores codes", trim_code, kept);
      chk("R8", "analog off in sleep", analog_en, 0);

      // R10: start while asleep is ignored
      start_wr = 1'b1;
      @(negedge clk) start_wr = 1'b0;
      @(negedge clk);
      chk("R10", "no launch while asleep", start_bit, 0);
      sleep = 1'b0;
      @(negedge clk);
      chk("R8", "codes kept after wake", trim_code, kept);
      chk("R8", "analog on after wake", analog_en, 1);
      chk("R8", "monitor still released after wake", mon0_oe, 0);

      // R9: monitor routing under random test patterns
      for (int i = 0; i < 24; i++) begin
         logic [3:0] ex;
         @(negedge clk);
         test_sel = 2'($urandom);
         {chg_sig, dis_sig, pc_clk, pc_dat} = 4'($urandom);
         #1;
         case (test_sel)
            2'b01:   ex = {1'b1, chg_sig, 1'b1, dis_sig};
            2'b10:   ex = {1'b1, pc_clk, 1'b1, pc_dat};
            default: ex = 4'b0000;
         endcase
         chk("R9", $sformatf("monitor routing sel=%0d", test_sel),
             {mon0_oe, mon0_val, mon1_test, mon1_val}, ex);
      end
      test_sel = 2'b00;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule